// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block collects error events from a packet FIFO and presents them to software as latched status bits. Each event input is a single-cycle pulse from the FIFO logic. The pulse sets its own status bit, and that bit stays set until software clears it by writing a one to it. A separate enable register selects which latched bits may raise the single active-high interrupt line.

Both registers are reached through a plain register port. The port carries an address, write data, a write strobe and a read strobe, and read data returns one cycle after the read strobe. The interrupt line is taken from a register, so it follows the status and enable contents one cycle later.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, all status bits, all enable bits, `irq_o` and `rdata_o` are 0.
- R2: A high level on `evt_i[i]` at a rising clock edge sets status bit i at that edge. The bit stays set after the event input returns low, and a bit never sets without an event.
- R3: A write to the status offset 0x0 clears every status bit whose write-data bit is 1, and several bits may clear in one write. Write-data bits that are 0 leave their status bits unchanged, and writing 1 to a bit that is already 0 leaves it at 0.
- R4: When an event and a write-one-to-clear target the same status bit in the same cycle, the bit ends up set.
- R5: The enable register sits at offset 0x4. It is a plain read/write register that holds write-data bits [NUM_EVT-1:0] and reads back in those same bits.
- R6: `irq_o` is high in the cycle after a cycle in which some status bit and its matching enable bit are both set. Otherwise it is low in that following cycle.
- R7: The status bit positions are fixed: bit 0 is the receive length-read underrun, bit 1 the receive read past packet end, bit 2 the receive data underrun and bit 3 the transmit overrun.
- R8: Status and enable bits above NUM_EVT-1 read as 0, and writes to them are ignored. A read of any address other than 0x0 or 0x4 returns 0.
- R9: `rdata_o` carries the addressed register's contents in the cycle after `re_i` is high, and is 0 in the cycle after `re_i` is low.
- R10: A write to the enable offset does not change any status bit. A write to the status offset does not change the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event pulses, one per status bit |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The hardest case to reach is an event pulse and a write-one-to-clear that target the same bit on the same edge. A bus-only or event-only driver never lines the two up. The bench therefore drives the event inputs and the write strobe together in one cycle, with a clear mask that covers both the bit that is pulsing and a bit that is already set. It then reads back the register to confirm that the set won and that the other bit cleared.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned EVT_RX_LEN_UNDER  = 0;
  localparam int unsigned EVT_RX_READ_PAST  = 1;
  localparam int unsigned EVT_RX_DATA_UNDER = 2;
  localparam int unsigned EVT_TX_OVERRUN    = 3;
  localparam int unsigned NUM_EVT_DEF       = 4;
  localparam int unsigned STAT_OFS_DEF      = 0;
  localparam int unsigned ENA_OFS_DEF       = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ENA  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned STAT_OFS = STAT_OFS_DEF,
  parameter int unsigned ENA_OFS  = ENA_OFS_DEF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] EnaA  = ADDR_W'(ENA_OFS);

  always_comb begin
    if (addr_i == StatA)     sel_o = SEL_STAT;
    else if (addr_i == EnaA) sel_o = SEL_ENA;
    else                     sel_o = SEL_NONE;
  end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned NUM_EVT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_en_i,
  input  logic [NUM_EVT-1:0] clr_mask_i,
  output logic [NUM_EVT-1:0] stat_o
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        bit_q <= 1'b0;
      else if (evt_i[i])                  bit_q <= 1'b1; // set beats clear
      else if (clr_en_i && clr_mask_i[i]) bit_q <= 1'b0;
    end
    assign stat_o[i] = bit_q;
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned NUM_EVT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  output logic [NUM_EVT-1:0] ena_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ena_o <= '0;
    else if (wr_i) ena_o <= wdata_i;
  end
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int unsigned NUM_EVT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] stat_i,
  input  logic [NUM_EVT-1:0] ena_i,
  output logic               irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(stat_i & ena_i);
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_EVT  = NUM_EVT_DEF,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STAT_OFS = STAT_OFS_DEF,
  parameter int unsigned ENA_OFS  = ENA_OFS_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam int unsigned PadW = DATA_W - NUM_EVT;

  reg_sel_e           sel;
  logic [NUM_EVT-1:0] stat_q;
  logic [NUM_EVT-1:0] ena_q;
  logic [DATA_W-1:0]  rdata_d;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_EVT];

  irq_addr_dec #(
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .ENA_OFS (ENA_OFS)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  irq_sticky_bank #(.NUM_EVT(NUM_EVT)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .clr_en_i  (we_i && (sel == SEL_STAT)),
    .clr_mask_i(wdata_i[NUM_EVT-1:0]),
    .stat_o    (stat_q)
  );

  irq_enable_reg #(.NUM_EVT(NUM_EVT)) u_ena (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (we_i && (sel == SEL_ENA)),
    .wdata_i(wdata_i[NUM_EVT-1:0]),
    .ena_o  (ena_q)
  );

  irq_out_reg #(.NUM_EVT(NUM_EVT)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stat_i(stat_q),
    .ena_i (ena_q),
    .irq_o (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata_d = {{PadW{1'b0}}, stat_q};
      SEL_ENA:  rdata_d = {{PadW{1'b0}}, ena_q};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rdata_d;
    else           rdata_o <= '0;
  end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int unsigned NUM_EVT  = 4,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STAT_OFS = 0,
  parameter int unsigned ENA_OFS  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_EVT-1:0] wlo_i,
  input logic               we_i,
  input logic               re_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_EVT-1:0] stat_q,
  input logic [NUM_EVT-1:0] ena_q
);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] EnaA  = ADDR_W'(ENA_OFS);

  logic wr_stat, wr_ena;
  assign wr_stat = we_i && (addr_i == StatA);
  assign wr_ena  = we_i && (addr_i == EnaA);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
    assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> stat_q[i]);
    assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stat_q[i] && !evt_i[i]) |=> !stat_q[i]);
    assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[i] && !(wr_stat && wlo_i[i])) |=> stat_q[i]);
    assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!evt_i[i] && wr_stat && wlo_i[i]) |=> !stat_q[i]);
  end

  assert_ena_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ena |=> (ena_q == $past(wlo_i)));
  assert_ena_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ena |=> $stable(ena_q));
  assert_irq_on_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_q & ena_q)) |=> irq_o);
  assert_irq_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(stat_q & ena_q)) |=> !irq_o);
  assert_idle_rdata_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> (rdata_o == '0));
  assert_unmapped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i != StatA && addr_i != EnaA) |=> (rdata_o == '0));
  assert_hi_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> (rdata_o[DATA_W-1:NUM_EVT] == '0));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .NUM_EVT (NUM_EVT),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .STAT_OFS(STAT_OFS),
  .ENA_OFS (ENA_OFS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .evt_i  (evt_i),
  .addr_i (addr_i),
  .wlo_i  (wdata_i[NUM_EVT-1:0]),
  .we_i   (we_i),
  .re_i   (re_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .stat_q (stat_q),
  .ena_q  (ena_q)
);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  localparam int NE = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_STAT = 4'h0;
  localparam logic [AW-1:0] A_ENA  = 4'h4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic          re = 1'b0;
  logic [DW-1:0] rdata;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  irq_status_ctrl uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .evt_i  (evt),
    .addr_i (addr),
    .wdata_i(wdata),
    .we_i   (we),
    .re_i   (re),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    exp_t it;
    it.exp = exp; it.tag = tag;
    @(negedge clk); addr = a; re = 1'b1;
    sb_q.push_back(it);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic pulse(logic [NE-1:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  task automatic chk_irq(logic e, string tag);
    check(irq == e, tag, {31'd0, irq}, {31'd0, e});
  endtask

  // monitor: compare read data one edge after a strobed read
  initial begin
    forever begin
      @(posedge clk);
      if (re) begin
        #2;
        if (sb_q.size() == 0) check(1'b0, "scoreboard empty", rdata, '0);
        else begin
          exp_t it;
          it = sb_q.pop_front();
          check(rdata == it.exp, it.tag, rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_irq(1'b0, "R1 irq reset");
    check(rdata == '0, "R1 rdata reset", rdata, '0);
    rd(A_STAT, 32'h0, "R1 status reset");
    rd(A_ENA,  32'h0, "R1 enable reset");

    pulse(4'b0001);
    rd(A_STAT, 32'h1, "R2 sticky bit0 / R7 rx length underrun");
    chk_irq(1'b0, "R6 masked irq stays low");

    wr(A_ENA, 32'hFFFF_FFFF);
    rd(A_ENA, 32'hF, "R5 enable readback / R8 upper bits zero");
    wr(A_ENA, 32'h1);
    chk_irq(1'b1, "R6 irq from enabled bit");

    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h1, "R3 write zero ignored");
    wr(A_STAT, 32'h2);
    rd(A_STAT, 32'h1, "R3 one to clear bit");
    wr(A_STAT, 32'hFFFF_FFF0);
    rd(A_STAT, 32'h1, "R8 undefined bits ignore writes");

    pulse(4'b1110);
    rd(A_STAT, 32'hF, "R2 multi event set");
    wr(A_STAT, 32'h5);
    chk_irq(1'b1, "R6 irq lags clear by one cycle");
    @(negedge clk);
    chk_irq(1'b0, "R6 irq drops after clear");
    rd(A_STAT, 32'hA, "R3 multi bit clear");

    // R4: set and clear on the same edge
    @(negedge clk); evt = 4'b0010; addr = A_STAT; wdata = 32'hA; we = 1'b1;
    @(negedge clk); evt = '0; we = 1'b0; wdata = '0;
    rd(A_STAT, 32'h2, "R4 set wins over clear");

    wr(A_STAT, 32'hF);
    pulse(4'b1000);
    rd(A_STAT, 32'h8, "R7 tx overrun at bit3");
    wr(A_STAT, 32'hF);
    pulse(4'b0100);
    rd(A_STAT, 32'h4, "R7 rx data underrun at bit2");

    rd(4'h8, 32'h0, "R8 unmapped read");
    rd(4'hC, 32'h0, "R8 unmapped read");

    wr(A_ENA, 32'h0);
    rd(A_STAT, 32'h4, "R10 enable write leaves status");
    wr(A_ENA, 32'h6);
    @(negedge clk);
    chk_irq(1'b1, "R6 irq via bit2 enable");
    wr(A_STAT, 32'hF);
    rd(A_ENA, 32'h6, "R10 status write leaves enable");
    @(negedge clk);
    chk_irq(1'b0, "R6 irq low after full clear");
    @(negedge clk);
    check(rdata == '0, "R9 idle rdata zero", rdata, '0);

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) check(1'b0, "scoreboard leftover", sb_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule